// File: doc/BRIEF.md
# Indexed Register Access Port

This block lets a host reach a bank of internal registers through a two-byte window in a 16-bit I/O address space. The window base is taken from a configuration input and is always aligned to eight bytes. Inside the window, the byte at offset 5 holds a pointer. The byte at offset 6 carries reads and writes to whichever bank register that pointer names.

To reach a register, the host first writes its number to offset 5. It then reads or writes offset 6 as often as it needs to. The pointer holds its value until the host writes it again. Toward the bank the block drives an index, write data, a write enable and a read enable. The bank answers a read combinationally on its read-data input in the same cycle. The block returns read data to the host one cycle after the read strobe.

Top module: `idx_port`

## Requirements
- R1: An access is inside the window when io_addr and base_addr agree in every bit above bit 2. Bits [2:0] of base_addr never affect decoding.
- R2: A write strobe at window offset 5 (io_addr[2:0] = 3'b101) loads the pointer from io_wdata[IDX_W-1:0], effective from the next cycle. The pointer resets to zero and is always driven on reg_idx.
- R3: A read strobe at offset 5 returns the pointer, zero-extended, on io_rdata in the next cycle. If the pointer is written in the same cycle, the value returned is the old pointer.
- R4: A write strobe at offset 6 (io_addr[2:0] = 3'b110) asserts reg_we in that same cycle, with reg_wdata equal to io_wdata and reg_idx equal to the current pointer.
- R5: A read strobe at offset 6 asserts reg_re for exactly that cycle. In the next cycle io_rdata equals the reg_rdata value presented during the strobe cycle.
- R6: Accesses outside the window, or at offsets 0 to 4 and 7 inside it, assert neither reg_we nor reg_re and leave the pointer unchanged. A read of any such address returns all ones.
- R7: io_rdata is all ones in reset and in every cycle that does not follow a read strobe.
- R8: A data access at offset 6 never changes the pointer; there is no auto-increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | ADDR_W | Window base; low three bits ignored |
| io_addr | input | ADDR_W | Host I/O address |
| io_wdata | input | DATA_W | Host write data |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_rdata | output | DATA_W | Host read data, one cycle after io_rd |
| reg_idx | output | IDX_W | Pointer value toward the bank |
| reg_wdata | output | DATA_W | Write data toward the bank |
| reg_we | output | 1 | Bank write enable |
| reg_re | output | 1 | Bank read enable |
| reg_rdata | input | DATA_W | Bank read data for reg_idx |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit data path and an 8-bit pointer. With these values the bench can model the whole 256-entry bank. It places the base at the top of the address space (16'hFFF8), where a neighbouring address wraps to zero, and also at a base whose low bits are set, so the alignment rule is tested. A pseudo-random phase mixes simultaneous read and write strobes with hits and misses on every window offset. Each cycle is compared against the behavioural model.

// File: rtl/idx_port.sv
module idx_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam int WIN_BITS = 3;
  localparam logic [WIN_BITS-1:0] PTR_OFS = 3'd5;
  localparam logic [WIN_BITS-1:0] DAT_OFS = 3'd6;

  initial begin
    if (IDX_W > DATA_W) $error("idx_port: IDX_W must not exceed DATA_W");
  end

  logic [ADDR_W-1:0] addr_diff;
  logic              in_win, ptr_sel, dat_sel;
  logic [IDX_W-1:0]  ptr_q;
  logic [DATA_W-1:0] ptr_ext, rdata_d;

  assign addr_diff = (io_addr ^ base_addr) >> WIN_BITS;
  assign in_win    = (addr_diff == '0);
  assign ptr_sel   = in_win && (io_addr[WIN_BITS-1:0] == PTR_OFS);
  assign dat_sel   = in_win && (io_addr[WIN_BITS-1:0] == DAT_OFS);

  assign reg_idx   = ptr_q;
  assign reg_wdata = io_wdata;
  assign reg_we    = io_wr && dat_sel;
  assign reg_re    = io_rd && dat_sel;

  always_comb begin
    ptr_ext = '0;
    ptr_ext[IDX_W-1:0] = ptr_q;
    rdata_d = '1;
    if (io_rd && ptr_sel)      rdata_d = ptr_ext;
    else if (io_rd && dat_sel) rdata_d = reg_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      io_rdata <= '1;
    end else begin
      if (io_wr && ptr_sel) ptr_q <= io_wdata[IDX_W-1:0];
      io_rdata <= rdata_d;
    end
  end

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && ptr_sel) |=> (reg_idx == $past(io_wdata[IDX_W-1:0]))); // R2
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && ptr_sel) |=> $stable(reg_idx)); // R8
  AST_DATA_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && dat_sel) |=> (io_rdata == $past(reg_rdata))); // R5
  AST_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !in_win) |=> (io_rdata == '1)); // R6
  AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> (io_rdata == '1)); // R7
  AST_STROBE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |-> in_win); // R1

endmodule

// File: tb/idx_port_tb_top.sv
`timescale 1ns/1ps
module idx_port_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] base_addr = 16'h0300;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_rdata, reg_wdata, reg_rdata;
  logic [7:0]  reg_idx;
  logic        reg_we, reg_re;

  int checks = 0, errors = 0, cyc = 0;
  string cur_tag = "R7";
  logic [7:0] mem [256];
  int   m_idx = 0;
  logic [7:0] m_rdata = 8'hFF;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  idx_port dut_i (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_idx];

  function automatic bit hit_at(input logic [15:0] a, input logic [2:0] o);
    return (((a ^ base_addr) >> 3) == 0) && (a[2:0] == o);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [7:0] nxt;
    if (!rst_n) begin
      m_idx = 0;
      m_rdata = 8'hFF;
    end else begin
      nxt = 8'hFF;
      if (io_rd && hit_at(io_addr, 3'd5)) nxt = m_idx[7:0];
      else if (io_rd && hit_at(io_addr, 3'd6)) nxt = mem[m_idx];
      if (io_wr && hit_at(io_addr, 3'd6)) mem[m_idx] <= io_wdata;
      if (io_wr && hit_at(io_addr, 3'd5)) m_idx = io_wdata;
      m_rdata = nxt;
    end
  end

  always @(negedge clk) begin
    chk(cur_tag, "io_rdata", io_rdata, m_rdata);
    chk("R2", "reg_idx", reg_idx, m_idx);
    if (rst_n) begin
      chk("R4", "reg_we", reg_we, io_wr && hit_at(io_addr, 3'd6));
      chk("R5", "reg_re", reg_re, io_rd && hit_at(io_addr, 3'd6));
      if (reg_we) chk("R4", "reg_wdata", reg_wdata, io_wdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic acc(input bit wr, input bit rd, input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    io_wr = 0; io_rd = 0;
  endtask

  task automatic rd_expect(input logic [15:0] a, input logic [7:0] exp, input string tag);
    acc(0, 1, a, 0);
    idle();
    chk(tag, "direct read", io_rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "reset io_rdata", io_rdata, 8'hFF);
    chk("R2", "reset reg_idx", reg_idx, 0);
    rst_n = 1;

    cur_tag = "R2";
    acc(1, 0, 16'h0305, 8'h2A); idle();
    chk("R2", "pointer load", reg_idx, 8'h2A);
    cur_tag = "R3";
    rd_expect(16'h0305, 8'h2A, "R3");

    cur_tag = "R4";
    acc(1, 0, 16'h0306, 8'h5C); idle();
    cur_tag = "R5";
    rd_expect(16'h0306, 8'h5C, "R5");
    cur_tag = "R8";
    acc(0, 1, 16'h0306, 0); acc(1, 0, 16'h0306, 8'h11); idle();
    chk("R8", "no auto-increment", reg_idx, 8'h2A);

    cur_tag = "R6";
    for (int o = 0; o < 8; o++) begin
      if (o == 5 || o == 6) continue;
      acc(1, 0, 16'h0300 + 16'(o), 8'h77); idle();
      chk("R6", "pointer after stray write", reg_idx, 8'h2A);
      rd_expect(16'h0300 + 16'(o), 8'hFF, "R6");
    end
    acc(1, 0, 16'h030D, 8'h99); idle();
    chk("R6", "outside window", reg_idx, 8'h2A);
    rd_expect(16'h030E, 8'hFF, "R6");

    cur_tag = "R1";
    base_addr = 16'h0347;
    acc(1, 0, 16'h0345, 8'h80); idle();
    chk("R1", "unaligned base", reg_idx, 8'h80);
    rd_expect(16'h0305, 8'hFF, "R1");
    base_addr = 16'hFFFF;
    acc(1, 0, 16'hFFFD, 8'hFE); idle();
    rd_expect(16'hFFFD, 8'hFE, "R1");
    rd_expect(16'h0005, 8'hFF, "R1");

    cur_tag = "R3";
    acc(1, 1, 16'hFFFD, 8'h03); idle();
    chk("R3", "old pointer on same-cycle write", io_rdata, 8'hFE);

    cur_tag = "R5";
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = (lcg[31:29] == 0) ? lcg[15:0] : {13'h1FFF, lcg[10:8]};
      acc(lcg[20], lcg[21], a, lcg[7:0]);
    end
    idle(); idle();

    cur_tag = "R7";
    idle();
    chk("R7", "idle ones", io_rdata, 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule